// File: doc/BRIEF.md
# Smart-Card T=0 Character Receiver

This block receives asynchronous characters from a smart card over one open-drain I/O line. It runs from an oversampling enable tick (OVS ticks per bit). A falling line in idle starts a character. The receiver checks the start bit at its middle and then samples eight data bits, least significant first, followed by an even parity bit. When the parity is wrong, the receiver tells the card by pulling the line low for one bit time, right after the parity bit. It then waits out a guard time before it looks for the next start bit.

Good characters go into a data register and raise a ready flag. Any parity error sets a sticky error flag and advances a saturating error counter, which clears when it is read. An inhibit input suppresses the low pulse. While inhibit is set, a bad character is kept as if it were good, but it is still counted and flagged.

Top module: `sc_t0_rx`

## Requirements
- R1: After reset, ioDriveLow, rxReady, parityErr, errCount and rxData are all 0.
- R2: A frame is one start bit at level 0, then data bits D0 first through D7, then a parity bit. A high line reads as 1. Parity is good when the nine data and parity bits together hold an even number of ones. Each bit is sampled OVS/2 ticks after its start, counting from the tick that first saw the line low.
- R3: If the line is high again at the middle of the start bit, the receiver returns to idle. No character is taken and no output changes.
- R4: A character with good parity is written to rxData and sets rxReady. No low pulse is driven.
- R5: With inhibitNack at 0, a parity error drives ioDriveLow high for exactly OVS ticks, starting at the end of the parity bit. rxData and rxReady are left unchanged.
- R6: Every parity error sets parityErr, whatever the inhibit setting. parityErr stays set until a clrStatus strobe.
- R7: Every parity error adds one to errCount, whatever the inhibit setting. At 2^CNT_W-1 the count stops and does not wrap.
- R8: A rdErrCnt strobe clears errCount. If a new parity error arrives in the same cycle as the strobe, errCount becomes 1.
- R9: With inhibitNack at 1, a character with bad parity drives no pulse, is written to rxData and sets rxReady.
- R10: A rdData strobe clears rxReady. If a character is stored in the same cycle as the strobe, rxReady stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | Oversampling enable, OVS ticks per bit |
| ioIn | input | 1 | Sampled level of the I/O line, already synchronous |
| ioDriveLow | output | 1 | 1 pulls the I/O line low; 0 releases it |
| inhibitNack | input | 1 | 1 suppresses the error pulse and keeps bad characters |
| rdData | input | 1 | Read strobe for the data register; clears rxReady |
| rdErrCnt | input | 1 | Read strobe for the error counter; clears it |
| clrStatus | input | 1 | Clears parityErr |
| rxData | output | 8 | Last stored character |
| rxReady | output | 1 | A stored character is waiting |
| parityErr | output | 1 | Sticky parity-error flag |
| errCount | output | CNT_W | Saturating parity-error count |

## Verification
The bench builds the block with OVS=8, GUARD_BITS=2 and CNT_W=3. With 3 counter bits, saturation at 7 takes only a handful of bad frames. With 8 ticks per bit and a tick every second clock, the parity-sample cycle falls at a fixed offset from the start edge. That fixed offset lets the bench land a read strobe in the very cycle a character finishes, which tests the counter and ready-flag collision rules. It also lets the bench count the low pulse length exactly in clocks.

// File: rtl/sc_t0_rx_pkg.sv
package sc_t0_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BITS, ST_PEND, ST_NACK, ST_GUARD
  } rxState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic sampleBit;  // take ioIn into the shift register
    logic endChar;    // this sample is the parity bit
  } rxStrobe_t;
endpackage

// File: rtl/sc_t0_rx_ctrl.sv
module sc_t0_rx_ctrl
  import sc_t0_rx_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int DATA_W     = 8,
  parameter int GUARD_BITS = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      ioIn,
  input  logic      inhibitNack,
  input  logic      charBad,
  output rxStrobe_t strobe,
  output logic      nackDrive
);
  localparam int HALF        = OVS / 2;
  localparam int GUARD_TICKS = GUARD_BITS * OVS;
  localparam int TCW         = $clog2(GUARD_TICKS + 1);
  localparam int BIW         = $clog2(DATA_W + 2);
  localparam logic [TCW-1:0] HALF_LAST  = TCW'(HALF - 1);
  localparam logic [TCW-1:0] BIT_LAST   = TCW'(OVS - 1);
  localparam logic [TCW-1:0] GUARD_LAST = TCW'(GUARD_TICKS - 1);
  localparam logic [BIW-1:0] PAR_IDX    = BIW'(DATA_W);

  rxState_e       state, stateNxt;
  logic [TCW-1:0] tickCnt, cntNxt;
  logic [BIW-1:0] bitIdx, idxNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = tickCnt;
    idxNxt   = bitIdx;
    strobe   = '0;
    if (bitTick) begin
      unique case (state)
        ST_IDLE: if (!ioIn) begin
          stateNxt = ST_START;
          cntNxt   = '0;
        end
        ST_START: if (tickCnt == HALF_LAST) begin
          cntNxt   = '0;
          idxNxt   = '0;
          stateNxt = ioIn ? ST_IDLE : ST_BITS;
        end else cntNxt = tickCnt + 1'b1;
        ST_BITS: if (tickCnt == BIT_LAST) begin
          cntNxt           = '0;
          strobe.sampleBit = 1'b1;
          if (bitIdx == PAR_IDX) begin
            strobe.endChar = 1'b1;
            stateNxt       = ST_PEND;
          end else idxNxt = bitIdx + 1'b1;
        end else cntNxt = tickCnt + 1'b1;
        ST_PEND: if (tickCnt == HALF_LAST) begin
          cntNxt   = '0;
          stateNxt = (charBad && !inhibitNack) ? ST_NACK : ST_GUARD;
        end else cntNxt = tickCnt + 1'b1;
        ST_NACK: if (tickCnt == BIT_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_GUARD;
        end else cntNxt = tickCnt + 1'b1;
        ST_GUARD: if (tickCnt == GUARD_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_IDLE;
        end else cntNxt = tickCnt + 1'b1;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNxt;
      tickCnt <= cntNxt;
      bitIdx  <= idxNxt;
    end
  end

  assign nackDrive = (state == ST_NACK);

  AST_NACK_ON_BAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nackDrive) |-> charBad && $past(!inhibitNack)); // R5
  AST_NO_NACK_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nackDrive) |-> $past(!inhibitNack)); // R9
endmodule

// File: rtl/sc_t0_rx_dp.sv
module sc_t0_rx_dp
  import sc_t0_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioIn,
  input  logic              inhibitNack,
  input  logic              rdData,
  input  logic              rdErrCnt,
  input  logic              clrStatus,
  input  rxStrobe_t         strobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic [CNT_W-1:0]  errCount,
  output logic              charBad
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W:0] shiftReg, frameNxt;
  logic            frameBad, storeNow, errNow;

  assign frameNxt = {ioIn, shiftReg[DATA_W:1]};
  assign frameBad = ^frameNxt;  // even parity over data and parity bit
  assign errNow   = strobe.endChar && frameBad;
  assign storeNow = strobe.endChar && (!frameBad || inhibitNack);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxData    <= '0;
      rxReady   <= 1'b0;
      parityErr <= 1'b0;
      errCount  <= '0;
      charBad   <= 1'b0;
    end else begin
      if (strobe.sampleBit) shiftReg <= frameNxt;
      if (strobe.endChar)   charBad  <= frameBad;
      if (storeNow) rxData <= frameNxt[DATA_W-1:0];
      if (storeNow)    rxReady <= 1'b1;
      else if (rdData) rxReady <= 1'b0;
      if (errNow)         parityErr <= 1'b1;
      else if (clrStatus) parityErr <= 1'b0;
      if (errNow) begin
        if (rdErrCnt)                 errCount <= CNT_W'(1);
        else if (errCount != CNT_MAX) errCount <= errCount + 1'b1;
      end else if (rdErrCnt) errCount <= '0;
    end
  end

  AST_BAD_NOT_STORED: assert property (@(posedge clk) disable iff (!rstN)
    errNow && !inhibitNack |=> $stable(rxData)); // R5
  AST_READY_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(strobe.endChar)); // R4
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    parityErr && !clrStatus |=> parityErr); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    errCount == CNT_MAX && !rdErrCnt |=> errCount == CNT_MAX); // R7
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    rdErrCnt && !errNow |=> errCount == '0); // R8
  AST_CNT_READ_ERR: assert property (@(posedge clk) disable iff (!rstN)
    rdErrCnt && errNow |=> errCount == CNT_W'(1)); // R8
  AST_READ_LOSES: assert property (@(posedge clk) disable iff (!rstN)
    rdData && storeNow |=> rxReady); // R10
endmodule

// File: rtl/sc_t0_rx.sv
module sc_t0_rx
  import sc_t0_rx_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int GUARD_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              ioIn,
  output logic              ioDriveLow,
  input  logic              inhibitNack,
  input  logic              rdData,
  input  logic              rdErrCnt,
  input  logic              clrStatus,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic [CNT_W-1:0]  errCount
);
  rxStrobe_t strobe;
  logic      charBad;

  sc_t0_rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W), .GUARD_BITS(GUARD_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .ioIn(ioIn),
    .inhibitNack(inhibitNack), .charBad(charBad),
    .strobe(strobe), .nackDrive(ioDriveLow)
  );

  sc_t0_rx_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ioIn(ioIn), .inhibitNack(inhibitNack),
    .rdData(rdData), .rdErrCnt(rdErrCnt), .clrStatus(clrStatus),
    .strobe(strobe), .rxData(rxData), .rxReady(rxReady),
    .parityErr(parityErr), .errCount(errCount), .charBad(charBad)
  );
endmodule

// File: tb/sc_t0_rx_tb.sv
module sc_t0_rx_tb;
  localparam int OVS      = 8;
  localparam int CNT_W    = 3;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;
  localparam int BIT_CLKS = 2 * OVS;            // tick every second clock
  localparam int PAR_CLK  = 2 * (OVS / 2 + 9 * OVS);

  logic clk = 1'b0, rstN = 1'b0, bitTick;
  logic cardLevel = 1'b1, inhibitNack = 1'b0;
  logic rdData = 1'b0, rdErrCnt = 1'b0, clrStatus = 1'b0;
  logic ioIn, ioDriveLow, rxReady, parityErr;
  logic [7:0] rxData;
  logic [CNT_W-1:0] errCount;

  int errors = 0, checks = 0;
  bit done = 0;
  int mData = 0, mReady = 0, mPerr = 0, mCnt = 0;

  always #2 clk = ~clk;
  always @(posedge clk) bitTick <= !rstN ? 1'b0 : ~bitTick;
  assign ioIn = cardLevel & ~ioDriveLow;

  sc_t0_rx #(.OVS(OVS), .DATA_W(8), .CNT_W(CNT_W), .GUARD_BITS(2)) u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .ioIn(ioIn),
    .ioDriveLow(ioDriveLow), .inhibitNack(inhibitNack), .rdData(rdData),
    .rdErrCnt(rdErrCnt), .clrStatus(clrStatus), .rxData(rxData),
    .rxReady(rxReady), .parityErr(parityErr), .errCount(errCount)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkState(string req);
    chk({req, " rxData"}, int'(rxData), mData);
    chk({req, " rxReady"}, int'(rxReady), mReady);
    chk({req, " parityErr"}, int'(parityErr), mPerr);
    chk({req, " errCount"}, int'(errCount), mCnt);
  endtask

  task automatic alignTick();
    @(negedge clk);
    while (!bitTick) @(negedge clk);
  endtask

  // readKind: 0 none, 1 rdErrCnt at parity cycle, 2 rdData at parity cycle
  task automatic sendChar(string req, logic [7:0] d, bit bad, int readKind);
    logic [9:0] frame;
    int nack = 0;
    frame = {(^d) ^ bad, d, 1'b0};
    alignTick();
    for (int c = 0; c < 10 * BIT_CLKS; c++) begin
      cardLevel = frame[c / BIT_CLKS];
      rdErrCnt  = (readKind == 1) && (c == PAR_CLK);
      rdData    = (readKind == 2) && (c == PAR_CLK);
      if (ioDriveLow) nack++;
      @(negedge clk);
    end
    cardLevel = 1'b1; rdErrCnt = 1'b0; rdData = 1'b0;
    for (int c = 0; c < 4 * BIT_CLKS; c++) begin
      if (ioDriveLow) nack++;
      @(negedge clk);
    end
    // reference model update
    if (bad) begin
      mPerr = 1;
      mCnt  = (readKind == 1) ? 1 : (mCnt < CNT_MAX ? mCnt + 1 : mCnt);
      if (inhibitNack) begin mData = d; mReady = 1; end
    end else begin
      mData = d; mReady = 1;
      if (readKind == 1) mCnt = 0;
    end
    chk({req, " nack clocks"}, nack, (bad && !inhibitNack) ? BIT_CLKS : 0);
    chkState(req);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 ioDriveLow", int'(ioDriveLow), 0);
    chkState("R1 reset");
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    sendChar("R4 R2 good 0xA5", 8'hA5, 0, 0);
    sendChar("R2 lsb-first 0x01", 8'h01, 0, 0);
    pulse(rdData); mReady = 0;
    chk("R10 rdData clears", int'(rxReady), 0);
    sendChar("R5 R6 R7 bad 0x3C", 8'h3C, 1, 0);
    pulse(clrStatus); mPerr = 0;
    chk("R6 clrStatus", int'(parityErr), 0);
    sendChar("R4 good 0x5A", 8'h5A, 0, 0);

    // false start: low for two ticks only
    alignTick();
    cardLevel = 1'b0;
    repeat (4) @(negedge clk);
    cardLevel = 1'b1;
    begin
      int nk = 0;
      for (int c = 0; c < 12 * BIT_CLKS; c++) begin
        if (ioDriveLow) nk++;
        @(negedge clk);
      end
      chk("R3 false start nack", nk, 0);
    end
    chkState("R3 false start");

    inhibitNack = 1'b1;
    sendChar("R9 R6 R7 inhibit bad 0xF0", 8'hF0, 1, 0);
    inhibitNack = 1'b0;
    for (int i = 0; i < 6; i++) sendChar("R7 saturate", 8'(8'h11 * i), 1, 0);
    chk("R7 at max", int'(errCount), CNT_MAX);
    pulse(rdErrCnt); mCnt = 0;
    chk("R8 read clears", int'(errCount), 0);
    sendChar("R7 count one", 8'h77, 1, 0);
    sendChar("R8 read with error", 8'h66, 1, 1);
    sendChar("R8 read with good", 8'h99, 0, 1);
    pulse(rdData); mReady = 0;
    sendChar("R10 store beats read", 8'hC3, 0, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule